// File: doc/BRIEF.md
# Guarded Data-Memory Access Controller

This block sits on a simple CPU register bus and gives software byte-wide read and write access to a small on-chip nonvolatile data array. Software places an address in a pair of address registers, then either requests a read or stages a byte in the data register and starts a write. A read lands in the data register on the cycle after the request. A write is accepted only through a deliberate protocol: a persistent write-enable bit must already be set, and the two key bytes 55h and then AAh must go to the key register right before the start bit is set. This protects the array against runaway code.

Once a write is accepted, the controller holds the address, data and control registers frozen for a parameterised number of clock cycles, which models the write cycle of the array. When the cycle ends, the byte is committed, the busy bit clears by itself, and a sticky completion flag raises the interrupt output until software clears it. The array is a behavioural register array, and the address width is a parameter.

Top module: `nvm_data_ctrl`

## Requirements
- R1: Bus offsets are 0 address low, 1 address high (only the upper ADDR_W-8 bits are kept), 2 data, 3 control, 4 key (reads 0), 5 flag (bit 0). After reset, every register reads 0 and `irq` is low.
- R2: Writing control with bit 0 (read request) set and bits 7 and 6 (memory selects) clear loads the array byte at {high,low} into the data register. The byte is readable on the next cycle, and bit 0 always reads back 0.
- R3: A read request written together with either memory-select bit set leaves the data register unchanged.
- R4: The data register keeps its value until another read is performed or software writes offset 2.
- R5: A write starts only when control is written with bit 1 (start) and bit 2 (write enable) set, both selects clear, write enable already 1 beforehand, and the key sequence armed. Control bit 1 then reads 1 for exactly WR_CYCLES cycles.
- R6: A control write that sets the start bit while write enable is still 0 only sets write enable and starts nothing.
- R7: The key sequence arms only on 55h then AAh written to offset 4 with no other bus access between them, and it must be redone for every byte. A 55h key write always restarts the sequence. Any other key value or any other access returns it to idle, and any control write consumes the armed state.
- R8: While a write is in progress, bus writes to offsets 0, 1, 2 and 3 are ignored.
- R9: When the write cycle ends, the staged byte is stored at the locked address, bit 1 clears, flag bit 0 sets, and `irq` follows the flag.
- R10: The flag is cleared only by software writing 0 to offset 5 bit 0. A software clear in the same cycle as completion leaves the flag set, and hardware never clears write enable.
- R11: A read request issued while a write is in progress does not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Write-complete interrupt, equal to the sticky flag |

## Verification
Two events can fall on the same clock edge: the end of the write cycle, which sets the flag, and a software write of 0 to the flag. The bench issues the flag-clearing write exactly WR_CYCLES cycles after the accepted start, so its edge is the completion edge, and it expects the flag and `irq` to stay high. A control write placed on that same edge must still be ignored, because the lock is judged on the pre-edge busy state. The bench's behavioural model predicts both outcomes and compares every read and `irq` on every clock.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        REG_ADR_LO = 3'd0,
        REG_ADR_HI = 3'd1,
        REG_DATA   = 3'd2,
        REG_CTRL   = 3'd3,
        REG_KEY    = 3'd4,
        REG_FLAG   = 3'd5
    } reg_sel_e;

    localparam int CTL_RD  = 0;
    localparam int CTL_WR  = 1;
    localparam int CTL_WEN = 2;
    localparam int CTL_CFG = 6;
    localparam int CTL_PGM = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_HALF  = 2'd1,
        KS_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic pgm_sel;
        logic cfg_sel;
        logic wen;
    } ctl_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        reg_sel_e   sel;
        logic [7:0] data;
    } bus_op_t;

    function automatic logic targets_data(input logic pgm, input logic cfg);
        return !pgm && !cfg;
    endfunction

    function automatic logic [7:0] pack_ctl(input ctl_t c, input logic busy);
        return {c.pgm_sel, c.cfg_sel, 3'b000, c.wen, busy, 1'b0};
    endfunction

endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
    import nvm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    output logic    armed
);

    key_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        if (op.wr || op.rd) begin
            if (op.wr && op.sel == REG_KEY) begin
                if (op.data == KEY_FIRST)
                    state_n = KS_HALF;
                else if (state_q == KS_HALF && op.data == KEY_SECOND)
                    state_n = KS_ARMED;
                else
                    state_n = KS_IDLE;
            end else begin
                state_n = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_IDLE;
        else     state_q <= state_n;
    end

    assign armed = (state_q == KS_ARMED);

    // R7: armed is entered only from the half state via the second key byte
    a_r7_arm_path: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_ARMED && $past(state_q) != KS_ARMED) |->
            $past(state_q == KS_HALF && op.wr && op.sel == REG_KEY && op.data == KEY_SECOND));

    // R7: any non-key access drops the sequence
    a_r7_other_access_idles: assert property (@(posedge clk) disable iff (rst)
        ((op.wr || op.rd) && !(op.wr && op.sel == REG_KEY)) |=> state_q == KS_IDLE);

endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
    parameter int WR_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R5: a start loads the full cycle count
    a_r5_start_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt_q == LOAD));

    // R5: the count steps down by one every busy cycle
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0 && !start) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/nvm_data_ctrl.sv
module nvm_data_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    localparam int HI_W = ADDR_W - 8;

    bus_op_t           op;
    logic [7:0]        lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [7:0]        data_q;
    ctl_t              ctl_q, ctl_n;
    logic              flag_q;
    logic              busy, done, armed;
    logic              ctrl_wr, rd_go, wr_go;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rd;
    logic [7:0]        rd_mux;

    assign op = '{wr: bus_wr, rd: bus_rd, sel: reg_sel_e'(bus_addr), data: bus_wdata};
    assign mem_addr = {hi_q, lo_q};

    nvm_unlock_fsm u_unlock (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .armed (armed)
    );

    nvm_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (wr_go),
        .busy  (busy),
        .done  (done)
    );

    nvm_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (done),
        .addr  (mem_addr),
        .wdata (data_q),
        .rdata (mem_rd)
    );

    always_comb begin
        ctl_n.pgm_sel = op.data[CTL_PGM];
        ctl_n.cfg_sel = op.data[CTL_CFG];
        ctl_n.wen     = op.data[CTL_WEN];
    end

    assign ctrl_wr = op.wr && (op.sel == REG_CTRL) && !busy;
    assign rd_go   = ctrl_wr && op.data[CTL_RD] && targets_data(ctl_n.pgm_sel, ctl_n.cfg_sel);
    assign wr_go   = ctrl_wr && op.data[CTL_WR] && ctl_n.wen && ctl_q.wen && armed
                     && targets_data(ctl_n.pgm_sel, ctl_n.cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            data_q <= '0;
            ctl_q  <= '0;
        end else if (op.wr && !busy) begin
            case (op.sel)
                REG_ADR_LO: lo_q   <= op.data;
                REG_ADR_HI: hi_q   <= op.data[HI_W-1:0];
                REG_DATA:   data_q <= op.data;
                REG_CTRL: begin
                    ctl_q <= ctl_n;
                    if (rd_go) data_q <= mem_rd;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (done)
            flag_q <= 1'b1;
        else if (op.wr && op.sel == REG_FLAG)
            flag_q <= op.data[0];
    end

    always_comb begin
        case (op.sel)
            REG_ADR_LO: rd_mux = lo_q;
            REG_ADR_HI: rd_mux = 8'(hi_q);
            REG_DATA:   rd_mux = data_q;
            REG_CTRL:   rd_mux = pack_ctl(ctl_q, busy);
            REG_FLAG:   rd_mux = {7'b0, flag_q};
            default:    rd_mux = 8'h00;
        endcase
    end

    assign bus_rdata = op.rd ? rd_mux : 8'h00;
    assign irq       = flag_q;

    // R6: no write cycle begins unless write enable was already set
    a_r6_start_needs_wen: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctl_q.wen));

    // R7: no write cycle begins without an armed key sequence
    a_r7_start_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed));

    // R8: address and staged byte stay frozen during a write cycle
    a_r8_lock_addr_data: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mem_addr) && $stable(data_q)));

    // R8: control settings stay frozen during a write cycle
    a_r8_lock_ctl: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctl_q));

    // R9: end of the write cycle raises the flag
    a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flag_q);

    // R10: the flag drops only through a software write
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(op.wr && op.sel == REG_FLAG)) |=> flag_q);

    // R10: hardware never clears write enable
    a_r10_wen_kept: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.wen && !(op.wr && op.sel == REG_CTRL)) |=> ctl_q.wen);

endmodule

// File: tb/nvm_data_ctrl_tb_top.sv
module nvm_data_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int WCYC       = 20;
    localparam int HI_MASK    = (1 << (AW - 8)) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_data_ctrl #(.ADDR_W(AW), .WR_CYCLES(WCYC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    byte unsigned m_mem [int];
    int  m_lo, m_hi, m_data, m_key, m_rem;
    bit  m_wen, m_pgm, m_cfg, m_busy, m_flag, m_fin, m_sel_ok;

    function automatic int mem_get(int a);
        return m_mem.exists(a) ? int'(m_mem[a]) : 0;
    endfunction

    function automatic int model_read(int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return m_data;
            3: return (int'(m_pgm) << 7) | (int'(m_cfg) << 6) | (int'(m_wen) << 2) | (int'(m_busy) << 1);
            5: return int'(m_flag);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lo = 0; m_hi = 0; m_data = 0; m_key = 0; m_rem = 0;
            m_wen = 0; m_pgm = 0; m_cfg = 0; m_busy = 0; m_flag = 0;
        end else begin
            m_fin = 0;
            if (m_busy) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) m_fin = 1;
            end
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: if (!m_busy) m_lo = int'(bus_wdata);
                    1: if (!m_busy) m_hi = int'(bus_wdata) & HI_MASK;
                    2: if (!m_busy) m_data = int'(bus_wdata);
                    3: if (!m_busy) begin
                        m_sel_ok = (bus_wdata[7:6] == 2'b00);
                        if (bus_wdata[0] && m_sel_ok) m_data = mem_get(m_hi * 256 + m_lo);
                        if (bus_wdata[1] && bus_wdata[2] && m_wen && m_key == 2 && m_sel_ok) begin
                            m_busy = 1;
                            m_rem  = WCYC;
                        end
                        m_wen = bus_wdata[2];
                        m_cfg = bus_wdata[6];
                        m_pgm = bus_wdata[7];
                    end
                    5: m_flag = bus_wdata[0];
                    default: ;
                endcase
            end
            if (bus_wr || bus_rd) begin
                if (bus_wr && bus_addr == 3'd4) begin
                    if (bus_wdata == 8'h55) m_key = 1;
                    else if (m_key == 1 && bus_wdata == 8'hAA) m_key = 2;
                    else m_key = 0;
                end else begin
                    m_key = 0;
                end
            end
            if (m_fin) begin
                m_mem[m_hi * 256 + m_lo] = 8'(m_data);
                m_busy = 0;
                m_flag = 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // R9: irq compared with the model flag on every clock
    always @(negedge clk) begin
        if (!rst && !finished) check("R9 irq", int'(irq), int'(m_flag));
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_wdata = '0;
        #1;
        check(tag, int'(bus_rdata), model_read(int'(a)));
        @(posedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic unlock();
        wr(3'd4, 8'h55);
        wr(3'd4, 8'hAA);
    endtask

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 6; a++) rd(3'(a), "R1 reset");

        // R5/R8/R11/R9: first guarded write
        wr(3'd0, 8'h34);
        wr(3'd1, 8'hFD);
        rd(3'd1, "R1 high mask");
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'h04);
        unlock();
        wr(3'd3, 8'h06);
        rd(3'd3, "R5 busy set");
        wr(3'd0, 8'h99);
        wr(3'd2, 8'h11);
        wr(3'd3, 8'h01);
        rd(3'd0, "R8 addr locked");
        rd(3'd2, "R11 read ignored while busy");
        idle(WCYC - 7);
        rd(3'd3, "R5 busy last cycle");
        idle(1);
        rd(3'd3, "R5 busy cleared");
        rd(3'd5, "R9 flag set");
        rd(3'd3, "R10 wen kept");
        wr(3'd5, 8'h00);
        rd(3'd5, "R10 flag cleared");

        // R4/R2: data holds, software overwrite, then read back
        rd(3'd2, "R4 data held");
        wr(3'd2, 8'h00);
        rd(3'd2, "R4 sw write");
        wr(3'd3, 8'h05);
        rd(3'd2, "R2 read data");
        rd(3'd3, "R2 rd bit clear");

        // R3: read with a select bit set
        wr(3'd2, 8'h77);
        wr(3'd3, 8'h85);
        rd(3'd2, "R3 no load pgm");
        wr(3'd3, 8'h45);
        rd(3'd2, "R3 no load cfg");

        // R6: enable and start in the same write
        wr(3'd3, 8'h00);
        unlock();
        wr(3'd3, 8'h06);
        rd(3'd3, "R6 no start");

        // R7: broken sequences
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h10);
        wr(3'd2, 8'hC3);
        wr(3'd4, 8'h55); rd(3'd0, "R7 probe"); wr(3'd4, 8'hAA);
        wr(3'd3, 8'h06);
        rd(3'd3, "R7 read between keys");
        wr(3'd4, 8'h55); wr(3'd4, 8'h12); wr(3'd4, 8'hAA);
        wr(3'd3, 8'h06);
        rd(3'd3, "R7 wrong key");
        wr(3'd4, 8'hAA); wr(3'd4, 8'h55); wr(3'd4, 8'h55); wr(3'd4, 8'hAA);
        wr(3'd3, 8'h06);
        rd(3'd3, "R7 restart on 55");
        idle(WCYC + 2);
        wr(3'd5, 8'h00);
        // second byte without a fresh sequence
        wr(3'd0, 8'h11);
        wr(3'd2, 8'h3C);
        wr(3'd3, 8'h06);
        rd(3'd3, "R7 per byte");

        // R10 collision: software clear on the completion edge
        wr(3'd5, 8'h01);
        unlock();
        wr(3'd3, 8'h06);
        idle(WCYC - 1);
        wr(3'd5, 8'h00);
        rd(3'd5, "R10 set wins over clear");
        rd(3'd3, "R10 wen kept after done");

        // R8 on the completion edge: control write ignored
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h22);
        wr(3'd2, 8'h81);
        unlock();
        wr(3'd3, 8'h06);
        idle(WCYC - 1);
        wr(3'd3, 8'h00);
        rd(3'd3, "R8 ctrl ignored at done");

        // R2: read back all committed bytes
        wr(3'd0, 8'h34); wr(3'd1, 8'h01); wr(3'd3, 8'h05);
        rd(3'd2, "R2 byte 134");
        wr(3'd0, 8'h10); wr(3'd1, 8'h02); wr(3'd3, 8'h05);
        rd(3'd2, "R2 byte 210");
        wr(3'd0, 8'h11); wr(3'd3, 8'h05);
        rd(3'd2, "R2 byte 211");
        wr(3'd0, 8'h22); wr(3'd3, 8'h05);
        rd(3'd2, "R2 byte 222");

        idle(2);
        summary();
    end

endmodule